// File: doc/BRIEF.md
# Endian-Aware Byte Lane Aligner

This block converts one processor access request per cycle into the fields a 32-bit system bus needs. The request carries an address, an access size, a read/write flag, an instruction-fetch flag, a compact-instruction-state flag, a signed-load flag and an endianness bit. The block produces:

- a bus address aligned to the size of the access;
- a four-bit byte-lane mask;
- store data copied into every lane that the value could occupy.

Instruction fetches always go out as full-word reads, whatever size the requester asks for. A flag marks a request whose address is not a multiple of its size.

The decoded request passes through one output register stage. The stage holds all request context, including the endianness in force when the request was issued. Read data that comes back while that context is on the outputs is decoded with it. The returned data is cut down to the addressed byte or halfword and then zero- or sign-extended. For fetches made in the compact 16-bit instruction state, both halfwords of the fetched word are presented in program order. The block keeps nothing from one access to the next.

Size encoding on `req_size_i` and `bus_size_o`: 2'b00 byte, 2'b01 halfword, 2'b10 word. The code 2'b11 is treated as a word. Lane bit k of the mask always means data bits [8k+7:8k] of the bus.

Top module: `endian_lane_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are cleared: `bus_valid_o`=0, `bus_lanes_o`=4'b0000, `bus_addr_o`=0, `misalign_o`=0.
- R2: A halfword access leaves with address bit 0 cleared. A word access leaves with address bits 1:0 cleared. A byte access keeps its address unchanged.
- R3: An instruction fetch (`req_fetch_i`=1) leaves as a word read: `bus_size_o`=2'b10, `bus_lanes_o`=4'b1111, `bus_write_o`=0. This holds for any requested size and either instruction state.
- R4: Little-endian lane mask (`req_big_i`=0): a byte at offset n sets only bit n. A halfword at offset 0 gives 4'b0011 and at offset 2 gives 4'b1100. A word gives 4'b1111.
- R5: Big-endian lane mask (`req_big_i`=1), still written in little-endian bit order: a byte at offset n sets only bit 3-n. A halfword at offset 0 gives 4'b1100 and at offset 2 gives 4'b0011. A word gives 4'b1111.
- R6: `misalign_o` is 1 when the unaligned input address has non-zero low bits for the effective size: bit 0 for halfwords, bits 1:0 for words and fetches. It is never set for a byte. A misaligned request still gets its aligned address and lane mask.
- R7: Store data is replicated. A byte fills all four lanes with `req_wdata_i[7:0]`. A halfword fills both halfword positions with `req_wdata_i[15:0]`. A word passes through unchanged.
- R8: For a read with `req_signed_i`=0, `ld_data_o` holds the byte or halfword taken from the lanes in the mask, zero-extended to 32 bits. A word read or a fetch returns all 32 bits.
- R9: For a byte or halfword read with `req_signed_i`=1, `ld_data_o` is sign-extended from the top bit of the extracted value.
- R10: A fetch made with `req_compact_i`=1 raises `pair_valid_o`. `instr_first_o` is then the halfword at the lower address: bus bits 15:0 in little-endian mode, bits 31:16 in big-endian mode. `instr_second_o` is the other halfword.
- R11: Endianness is taken per request. Back-to-back requests with different `req_big_i` values each get their own mask and read extraction.
- R12: Outputs appear one clock after the request is sampled and hold until the next edge. `bus_valid_o` follows `req_valid_i` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Unaligned request address |
| req_size_i | input | 2 | Access size: 00 byte, 01 half, 10/11 word |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_fetch_i | input | 1 | Instruction fetch |
| req_compact_i | input | 1 | Requester is in compact 16-bit instruction state |
| req_signed_i | input | 1 | Sign-extend a byte or halfword load |
| req_big_i | input | 1 | 1 = big-endian for this request |
| req_wdata_i | input | 32 | Store data, right-justified |
| bus_rdata_i | input | 32 | Bus read data for the access on the outputs |
| bus_valid_o | output | 1 | Bus request valid |
| bus_addr_o | output | 32 | Aligned bus address |
| bus_size_o | output | 2 | Effective bus size |
| bus_write_o | output | 1 | Bus write |
| bus_lanes_o | output | 4 | Byte-lane mask, little-endian bit order |
| bus_wdata_o | output | 32 | Lane-replicated store data |
| misalign_o | output | 1 | Request address was misaligned |
| ld_data_o | output | 32 | Extracted and extended load data |
| instr_first_o | output | 16 | Earlier instruction of a compact fetch pair |
| instr_second_o | output | 16 | Later instruction of a compact fetch pair |
| pair_valid_o | output | 1 | Instruction pair outputs are meaningful |

## Verification
The assertions assume that `rst` is high from time zero for at least one edge. They also assume that `bus_rdata_i` belongs to the access currently on the outputs, so a read check looks only at the registered context. The stimulus keeps to this: every request is driven at a falling edge, and the return data is driven together with it and held until the outputs for that request have been sampled. Misaligned addresses, the reserved size code and fetches that carry byte or halfword sizes are all applied on purpose. None of the assertions excludes them.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int ADDR_W   = 32;
    localparam int BUS_W    = 32;
    localparam int LANES    = BUS_W / 8;
    localparam int OFF_W    = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        acc_size_e         size;
        logic              write;
        logic              fetch;
        logic              compact;
        logic              sext;
        logic              big;
        logic              misalign;
        logic [LANES-1:0]  lanes;
        logic [BUS_W-1:0]  wdata;
    } beat_t;

    // Fetches and the reserved code become full-width accesses.
    function automatic acc_size_e eff_size(input logic [1:0] sz, input logic fetch);
        acc_size_e r;
        if (fetch || sz == SZ_RSVD || sz == SZ_WORD) r = SZ_WORD;
        else if (sz == SZ_HALF)                      r = SZ_HALF;
        else                                         r = SZ_BYTE;
        return r;
    endfunction

    // Low-address bits that must be zero for a given size.
    function automatic logic [OFF_W-1:0] low_bits(input acc_size_e sz);
        logic [OFF_W-1:0] r;
        case (sz)
            SZ_BYTE: r = '0;
            SZ_HALF: r = OFF_W'(1);
            default: r = '1;
        endcase
        return r;
    endfunction

    // Mask bit k always names bus bits [8k+7:8k].
    function automatic logic [LANES-1:0] lane_mask(input acc_size_e sz,
                                                   input logic [OFF_W-1:0] off,
                                                   input logic big);
        logic [LANES-1:0] r;
        case (sz)
            SZ_BYTE: r = big ? (LANES'(1) << (OFF_W'(LANES-1) - off))
                             : (LANES'(1) << off);
            SZ_HALF: r = (off[1] ^ big) ? 4'b1100 : 4'b0011;
            default: r = '1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lane_req_decode.sv
module lane_req_decode
    import lane_pkg::*;
(
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              write_i,
    input  logic              fetch_i,
    input  logic              compact_i,
    input  logic              signed_i,
    input  logic              big_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output beat_t             beat_o
);

    acc_size_e        sz;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] need_zero;
    logic [BUS_W-1:0] rep_data;

    assign sz        = eff_size(size_i, fetch_i);
    assign off       = addr_i[OFF_W-1:0];
    assign need_zero = low_bits(sz);

    for (genvar k = 0; k < LANES; k++) begin : g_rep
        always_comb begin
            case (sz)
                SZ_BYTE: rep_data[8*k +: 8] = wdata_i[7:0];
                SZ_HALF: rep_data[8*k +: 8] = wdata_i[8*(k%2) +: 8];
                default: rep_data[8*k +: 8] = wdata_i[8*k +: 8];
            endcase
        end
    end

    always_comb begin
        beat_o          = '0;
        beat_o.valid    = valid_i;
        beat_o.addr     = {addr_i[ADDR_W-1:OFF_W], off & ~need_zero};
        beat_o.size     = sz;
        beat_o.write    = write_i & ~fetch_i;
        beat_o.fetch    = fetch_i;
        beat_o.compact  = compact_i;
        beat_o.sext     = signed_i;
        beat_o.big      = big_i;
        beat_o.misalign = |(off & need_zero);
        beat_o.lanes    = lane_mask(sz, off & ~need_zero, big_i);
        beat_o.wdata    = rep_data;
    end

    always_comb begin
        if (valid_i && sz == SZ_BYTE)
            a_r6_byte_never_misaligned: assert (beat_o.misalign == 1'b0);
    end

endmodule

// File: rtl/lane_stage.sv
module lane_stage
    import lane_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t d_i,
    output beat_t q_o
);

    if (OUT_REG) begin : g_reg
        beat_t q_r;
        always_ff @(posedge clk) begin
            if (rst) q_r <= '0;
            else     q_r <= d_i;
        end
        assign q_o = q_r;

        a_r1_reset_clears: assert property (@(posedge clk)
            rst |=> (q_o.valid == 1'b0 && q_o.lanes == '0 && q_o.misalign == 1'b0));

        a_r12_valid_delay: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (q_o.valid == $past(d_i.valid)));
    end else begin : g_pass
        assign q_o = d_i;
    end

endmodule

// File: rtl/lane_rd_extract.sv
module lane_rd_extract
    import lane_pkg::*;
(
    input  beat_t            ctx_i,
    input  logic [BUS_W-1:0] rdata_i,
    output logic [BUS_W-1:0] ld_data_o,
    output logic [15:0]      first_o,
    output logic [15:0]      second_o,
    output logic             pair_o
);

    logic [7:0]  byte_v;
    logic [15:0] half_v;

    // Byte value is the lane picked out by the mask.
    always_comb begin
        byte_v = '0;
        for (int k = 0; k < LANES; k++) begin
            if (ctx_i.lanes[k]) byte_v = byte_v | rdata_i[8*k +: 8];
        end
    end

    assign half_v = ctx_i.lanes[2] ? rdata_i[31:16] : rdata_i[15:0];

    always_comb begin
        case (ctx_i.size)
            SZ_BYTE: ld_data_o = {{(BUS_W-8){ctx_i.sext & byte_v[7]}}, byte_v};
            SZ_HALF: ld_data_o = {{(BUS_W-16){ctx_i.sext & half_v[15]}}, half_v};
            default: ld_data_o = rdata_i;
        endcase
    end

    assign pair_o   = ctx_i.fetch & ctx_i.compact;
    assign first_o  = ctx_i.big ? rdata_i[31:16] : rdata_i[15:0];
    assign second_o = ctx_i.big ? rdata_i[15:0]  : rdata_i[31:16];

    always_comb begin
        if (ctx_i.valid && ctx_i.size == SZ_BYTE && !ctx_i.write)
            a_r8_single_lane: assert ($onehot0(ctx_i.lanes) && ctx_i.lanes != '0);
    end

endmodule

// File: rtl/endian_lane_aligner.sv
module endian_lane_aligner
    import lane_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic              req_write_i,
    input  logic              req_fetch_i,
    input  logic              req_compact_i,
    input  logic              req_signed_i,
    input  logic              req_big_i,
    input  logic [BUS_W-1:0]  req_wdata_i,
    input  logic [BUS_W-1:0]  bus_rdata_i,
    output logic              bus_valid_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [1:0]        bus_size_o,
    output logic              bus_write_o,
    output logic [LANES-1:0]  bus_lanes_o,
    output logic [BUS_W-1:0]  bus_wdata_o,
    output logic              misalign_o,
    output logic [BUS_W-1:0]  ld_data_o,
    output logic [15:0]       instr_first_o,
    output logic [15:0]       instr_second_o,
    output logic              pair_valid_o
);

    beat_t dec_beat;
    beat_t out_beat;

    lane_req_decode u_decode (
        .valid_i   (req_valid_i),
        .addr_i    (req_addr_i),
        .size_i    (req_size_i),
        .write_i   (req_write_i),
        .fetch_i   (req_fetch_i),
        .compact_i (req_compact_i),
        .signed_i  (req_signed_i),
        .big_i     (req_big_i),
        .wdata_i   (req_wdata_i),
        .beat_o    (dec_beat)
    );

    lane_stage #(.OUT_REG(OUT_REG)) u_stage (
        .clk (clk),
        .rst (rst),
        .d_i (dec_beat),
        .q_o (out_beat)
    );

    lane_rd_extract u_extract (
        .ctx_i     (out_beat),
        .rdata_i   (bus_rdata_i),
        .ld_data_o (ld_data_o),
        .first_o   (instr_first_o),
        .second_o  (instr_second_o),
        .pair_o    (pair_valid_o)
    );

    assign bus_valid_o = out_beat.valid;
    assign bus_addr_o  = out_beat.addr;
    assign bus_size_o  = out_beat.size;
    assign bus_write_o = out_beat.write;
    assign bus_lanes_o = out_beat.lanes;
    assign bus_wdata_o = out_beat.wdata;
    assign misalign_o  = out_beat.misalign;

    a_r2_half_aligned: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_o && bus_size_o == SZ_HALF) |-> (bus_addr_o[0] == 1'b0));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_o && bus_size_o == SZ_WORD) |-> (bus_addr_o[1:0] == 2'b00));

    a_r4_lane_count: assert property (@(posedge clk) disable iff (rst)
        bus_valid_o |-> ($countones(bus_lanes_o) ==
            ((bus_size_o == SZ_BYTE) ? 1 : (bus_size_o == SZ_HALF) ? 2 : 4)));

    a_r7_byte_replicated: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_o && bus_write_o && bus_size_o == SZ_BYTE) |->
            (bus_wdata_o[31:24] == bus_wdata_o[7:0] && bus_wdata_o[15:8] == bus_wdata_o[7:0]));

    a_r9_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_o && !bus_write_o && out_beat.sext && bus_size_o == SZ_BYTE && ld_data_o[7])
            |-> (ld_data_o[31:8] == 24'hFFFFFF));

    if (OUT_REG) begin : g_seq_checks
        a_r3_fetch_word_read: assert property (@(posedge clk) disable iff (rst)
            (req_valid_i && req_fetch_i) |=>
                (bus_size_o == SZ_WORD && bus_lanes_o == 4'b1111 && !bus_write_o));

        a_r11_endian_carried: assert property (@(posedge clk) disable iff (rst)
            (req_valid_i && req_size_i == SZ_BYTE && !req_fetch_i && req_addr_i[1:0] == 2'b00)
                |=> (bus_lanes_o == ($past(req_big_i) ? 4'b1000 : 4'b0001)));
    end

endmodule

// File: tb/endian_lane_aligner_tb_top.sv
module endian_lane_aligner_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid_i, req_write_i, req_fetch_i, req_compact_i, req_signed_i, req_big_i;
    logic [31:0] req_addr_i, req_wdata_i, bus_rdata_i;
    logic [1:0]  req_size_i;
    logic        bus_valid_o, bus_write_o, misalign_o, pair_valid_o;
    logic [31:0] bus_addr_o, bus_wdata_o, ld_data_o;
    logic [1:0]  bus_size_o;
    logic [3:0]  bus_lanes_o;
    logic [15:0] instr_first_o, instr_second_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    endian_lane_aligner dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_size_i(req_size_i),
        .req_write_i(req_write_i), .req_fetch_i(req_fetch_i), .req_compact_i(req_compact_i),
        .req_signed_i(req_signed_i), .req_big_i(req_big_i), .req_wdata_i(req_wdata_i),
        .bus_rdata_i(bus_rdata_i),
        .bus_valid_o(bus_valid_o), .bus_addr_o(bus_addr_o), .bus_size_o(bus_size_o),
        .bus_write_o(bus_write_o), .bus_lanes_o(bus_lanes_o), .bus_wdata_o(bus_wdata_o),
        .misalign_o(misalign_o), .ld_data_o(ld_data_o),
        .instr_first_o(instr_first_o), .instr_second_o(instr_second_o),
        .pair_valid_o(pair_valid_o)
    );

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] le_mask(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'b00)      return 4'b0001 << off;
        else if (sz == 2'b01) return off[1] ? 4'b1100 : 4'b0011;
        else                  return 4'b1111;
    endfunction

    function automatic logic [3:0] rev4(input logic [3:0] m);
        return {m[0], m[1], m[2], m[3]};
    endfunction

    task automatic drive(input logic v, input logic [31:0] a, input logic [1:0] sz, input logic wr,
                         input logic fe, input logic cp, input logic sx, input logic bg,
                         input logic [31:0] wd, input logic [31:0] rd);
        @(negedge clk);
        req_valid_i = v; req_addr_i = a; req_size_i = sz; req_write_i = wr;
        req_fetch_i = fe; req_compact_i = cp; req_signed_i = sx; req_big_i = bg;
        req_wdata_i = wd; bus_rdata_i = rd;
    endtask

    // Applies one request, then checks every output one edge later.
    task automatic access(input string tag, input logic [31:0] a, input logic [1:0] sz, input logic wr,
                          input logic fe, input logic cp, input logic sx, input logic bg,
                          input logic [31:0] wd, input logic [31:0] rd);
        logic [1:0]  esz;
        logic [3:0]  em;
        logic [31:0] ea, ewd, eld;
        logic        emis;
        logic [7:0]  bv;
        logic [15:0] hv;
        drive(1'b1, a, sz, wr, fe, cp, sx, bg, wd, rd);
        esz  = (fe || sz[1]) ? 2'b10 : sz;
        em   = bg ? rev4(le_mask(esz, a[1:0])) : le_mask(esz, a[1:0]);
        ea   = (esz == 2'b00) ? a : (esz == 2'b01) ? {a[31:1], 1'b0} : {a[31:2], 2'b00};
        emis = (esz == 2'b01) ? a[0] : (esz == 2'b10) ? (a[1:0] != 2'b00) : 1'b0;
        ewd  = (esz == 2'b00) ? {4{wd[7:0]}} : (esz == 2'b01) ? {2{wd[15:0]}} : wd;
        bv   = bg ? rd[8*(3-a[1:0]) +: 8] : rd[8*a[1:0] +: 8];
        hv   = bg ? rd[16*(1-a[1]) +: 16] : rd[16*a[1] +: 16];
        eld  = (esz == 2'b00) ? {{24{sx & bv[7]}}, bv} :
               (esz == 2'b01) ? {{16{sx & hv[15]}}, hv} : rd;
        @(posedge clk);
        #5;
        cmp("R12", {tag, " valid"}, {31'd0, bus_valid_o}, 32'd1);
        cmp("R2",  {tag, " addr"},  bus_addr_o, ea);
        cmp(fe ? "R3" : "R2", {tag, " size"}, {30'd0, bus_size_o}, {30'd0, esz});
        cmp(fe ? "R3" : (bg ? "R5" : "R4"), {tag, " lanes"}, {28'd0, bus_lanes_o}, {28'd0, em});
        cmp(fe ? "R3" : "R7", {tag, " write"}, {31'd0, bus_write_o}, {31'd0, wr & ~fe});
        cmp("R6", {tag, " misalign"}, {31'd0, misalign_o}, {31'd0, emis});
        if (wr && !fe) cmp("R7", {tag, " wdata"}, bus_wdata_o, ewd);
        else           cmp(sx ? "R9" : "R8", {tag, " ld_data"}, ld_data_o, eld);
        cmp("R10", {tag, " pair_valid"}, {31'd0, pair_valid_o}, {31'd0, fe & cp});
        if (fe && cp) begin
            cmp("R10", {tag, " first"},  {16'd0, instr_first_o},  {16'd0, bg ? rd[31:16] : rd[15:0]});
            cmp("R10", {tag, " second"}, {16'd0, instr_second_o}, {16'd0, bg ? rd[15:0] : rd[31:16]});
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        cmp("R1", "reset valid",    {31'd0, bus_valid_o}, 32'd0);
        cmp("R1", "reset lanes",    {28'd0, bus_lanes_o}, 32'd0);
        cmp("R1", "reset addr",     bus_addr_o, 32'd0);
        cmp("R1", "reset misalign", {31'd0, misalign_o}, 32'd0);
    endtask

    task automatic t_little_masks();  // R4, R2
        for (int o = 0; o < 4; o++) access("R4 le byte", 32'h1000_0000 + o, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'hA1B2C3D4);
        access("R4 le half0", 32'h2000_0010, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h1234_5678);
        access("R4 le half2", 32'h2000_0012, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h1234_5678);
        access("R4 le word",  32'h2000_0020, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'hCAFE_F00D);
    endtask

    task automatic t_big_masks();  // R5
        for (int o = 0; o < 4; o++) access("R5 be byte", 32'h3000_0100 + o, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'hA1B2C3D4);
        access("R5 be half0", 32'h3000_0200, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'h8765_4321);
        access("R5 be half2", 32'h3000_0202, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'h8765_4321);
        access("R5 be rsvd size", 32'h3000_0300, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'h0BAD_BEEF);
    endtask

    task automatic t_fetch();  // R3, R10
        access("R3 fetch byte size", 32'h0000_4003, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hE59F_0010);
        access("R3 fetch half size", 32'h0000_4002, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 0, 32'hB510_4668);
        access("R10 pair le", 32'h0000_4008, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 32'h2001_4770);
        access("R10 pair be", 32'h0000_400C, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 0, 32'h2001_4770);
    endtask

    task automatic t_misalign();  // R6
        access("R6 half odd",  32'h5000_0003, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h1122_3344);
        access("R6 word off1", 32'h5000_0005, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h99AA_BBCC, 0);
        access("R6 word off2", 32'h5000_000A, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h5566_7788);
        access("R6 byte odd",  32'h5000_0007, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'h5566_7788);
    endtask

    task automatic t_stores();  // R7
        access("R7 byte store", 32'h6000_0001, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_56A5, 0);
        access("R7 half store", 32'h6000_0002, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 0);
        access("R7 word store", 32'h6000_0004, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0102_0304, 0);
    endtask

    task automatic t_loads_signed();  // R8, R9
        access("R9 sbyte le",  32'h7000_0002, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 32'h1280_3456);
        access("R9 sbyte be",  32'h7000_0001, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 32'h12F0_3456);
        access("R9 shalf be",  32'h7000_0002, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 32'h1234_9ABC);
        access("R9 spos half", 32'h7000_0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 32'hFFFF_7ABC);
        access("R8 ubyte high", 32'h7000_0003, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'hF0_00_00_00);
    endtask

    task automatic t_endian_switch();  // R11, R12
        access("R11 first le",  32'h8000_0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h4433_2211);
        drive(1'b1, 32'h8000_0000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'h4433_2211);
        #1;
        cmp("R12", "R12 held before edge", {28'd0, bus_lanes_o}, 32'h1);
        @(posedge clk); #5;
        cmp("R11", "R11 be next lanes", {28'd0, bus_lanes_o}, 32'h8);
        cmp("R11", "R11 be next ld", ld_data_o, 32'h44);
        drive(1'b0, 32'h8000_0004, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
        @(posedge clk); #5;
        cmp("R12", "R12 idle valid", {31'd0, bus_valid_o}, 32'd0);
    endtask

    initial begin
        rst = 1'b1;
        req_valid_i = 0; req_addr_i = 0; req_size_i = 0; req_write_i = 0; req_fetch_i = 0;
        req_compact_i = 0; req_signed_i = 0; req_big_i = 0; req_wdata_i = 0; bus_rdata_i = 0;
        repeat (3) @(posedge clk);
        t_reset_state();
        rst = 1'b0;
        t_little_masks();
        t_big_masks();
        t_fetch();
        t_misalign();
        t_stores();
        t_loads_signed();
        t_endian_switch();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule